// File: doc/BRIEF.md
# Broadcast-Lane Saturating Rounding Multiply-Subtract Unit

This block is a lane-parallel signed integer datapath for 64-bit or 128-bit vectors. One lane of the second operand vector is picked by an index field and broadcast to every lane. Each lane of the first operand is multiplied by that broadcast value. The product is doubled and subtracted, at full precision and with no intermediate clamping, from the accumulator lane after the accumulator has been shifted up by the lane width. The difference is rounded to nearest and reduced to its high half. That value is then clamped to the signed lane range.

A lane-size code picks 16-bit or 32-bit lanes. A width select picks a 64-bit or a 128-bit vector, and a scalar select restricts the work to lane 0. The result and an illegal-encoding indication are registered and appear one cycle after the input is marked valid. A sticky flag records that any lane in any accepted operation was clamped. Only a synchronous clear input resets that flag.

Top module: `sqm_unit`

## Requirements
- R1: Lane-size code 2'b01 selects 16-bit lanes and code 2'b10 selects 32-bit lanes.
- R2: Each lane result is ((acc << E) - 2*a*b + 2^(E-1)) >>> E, where E is the lane width. The operands are signed, and the intermediate is exact and never clamped.
- R3: A rounded value outside the signed E-bit range is replaced by the nearest bound, 2^(E-1)-1 or -2^(E-1).
- R4: An accepted, legal operation that clamps any active lane sets `sat_flag`. The flag is cleared only by `sat_clr`. When both happen in one cycle, the set wins.
- R5: The broadcast lane index is {idx_h, idx_l, idx_m} for 16-bit lanes and {idx_h, idx_l} for 32-bit lanes. Lane k occupies bits [k*E +: E] of `vec_b`.
- R6: With `wide_q` = 0 the vector is 64 bits wide (4 or 2 lanes) and `result[127:64]` is zero. With `wide_q` = 1 it is 128 bits wide (8 or 4 lanes).
- R7: With `scalar_mode` = 1 only lane 0 is computed, and every result bit above that lane is zero.
- R8: Codes 2'b00 and 2'b11 raise `bad_code` together with `out_valid`. In that case the result is zero and `sat_flag` is left unchanged.
- R9: `out_valid` follows `in_valid` by exactly one cycle. The result and `bad_code` hold their values in cycles without a valid input.
- R10: Synchronous reset clears `out_valid`, `result`, `bad_code` and `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| lane_code | input | 2 | Lane size: 01 = 16-bit, 10 = 32-bit, others illegal |
| wide_q | input | 1 | 0 = 64-bit vector, 1 = 128-bit vector |
| scalar_mode | input | 1 | Compute lane 0 only |
| idx_h | input | 1 | Index bit, most significant |
| idx_l | input | 1 | Index bit, middle |
| idx_m | input | 1 | Index bit, least significant (16-bit lanes only) |
| vec_a | input | 128 | First operand vector |
| vec_b | input | 128 | Vector supplying the broadcast lane |
| vec_acc | input | 128 | Accumulator vector |
| sat_clr | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Result vector |
| sat_flag | output | 1 | Sticky clamp indication |
| bad_code | output | 1 | Illegal lane-size code seen |

## Verification
The assertions check the control behaviour on every cycle:
- the one-cycle valid latency;
- zero upper halves in 64-bit and scalar operations;
- a zero result for illegal codes;
- a flag that never drops without a clear and never rises without an accepted input;
- the reset state.

The arithmetic needs the bench scenarios, which compare each lane against a wide-integer model:
- rounding and clamping of each lane;
- lane selection by the index bits;
- the most-negative corner;
- the set-over-clear priority of the flag.

// File: rtl/sqm_pkg.sv
package sqm_pkg;
  typedef enum logic [1:0] {
    LC_RSV_LO = 2'b00,
    LC_HALF   = 2'b01,
    LC_SINGLE = 2'b10,
    LC_RSV_HI = 2'b11
  } lane_code_e;

  localparam int HALF_W   = 16;
  localparam int SINGLE_W = 32;
endpackage

// File: rtl/sqm_bsel.sv
// Picks the broadcast lane of the second operand for each lane size.
module sqm_bsel #(
  parameter int VEC_W = 128,
  parameter int HW    = 16,
  parameter int SW    = 32
) (
  input  logic [VEC_W-1:0] vec_b,
  input  logic             idx_h,
  input  logic             idx_l,
  input  logic             idx_m,
  output logic [HW-1:0]    b_half,
  output logic [SW-1:0]    b_single
);
  logic [2:0] idx_half;
  logic [1:0] idx_single;

  assign idx_half   = {idx_h, idx_l, idx_m};
  assign idx_single = {idx_h, idx_l};
  assign b_half     = vec_b[idx_half*HW +: HW];
  assign b_single   = vec_b[idx_single*SW +: SW];
endmodule

// File: rtl/sqm_lane.sv
// One lane: exact doubled multiply-subtract, round, take high half, clamp.
module sqm_lane #(
  parameter int ESIZE = 16
) (
  input  logic [ESIZE-1:0] a,
  input  logic [ESIZE-1:0] b,
  input  logic [ESIZE-1:0] acc,
  output logic [ESIZE-1:0] res,
  output logic             sat
);
  localparam int W = 2*ESIZE + 3;

  logic signed [2*ESIZE-1:0] prod;
  logic signed [W-1:0]       acc_up, prod_x2, diff, rnd, shifted;
  logic [W-ESIZE:0]          top_bits;

  always_comb begin
    prod     = $signed(a) * $signed(b);
    acc_up   = $signed({{3{acc[ESIZE-1]}}, acc, {ESIZE{1'b0}}});
    prod_x2  = $signed({{2{prod[2*ESIZE-1]}}, prod, 1'b0});
    diff     = acc_up - prod_x2;
    rnd      = diff + $signed(W'(1) << (ESIZE-1));
    shifted  = rnd >>> ESIZE;
    top_bits = shifted[W-1:ESIZE-1];
    sat      = !((&top_bits) || !(|top_bits));
    if (!sat)
      res = shifted[ESIZE-1:0];
    else if (shifted[W-1])
      res = {1'b1, {(ESIZE-1){1'b0}}};
    else
      res = {1'b0, {(ESIZE-1){1'b1}}};
  end
endmodule

// File: rtl/sqm_unit.sv
module sqm_unit
  import sqm_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       lane_code,
  input  logic             wide_q,
  input  logic             scalar_mode,
  input  logic             idx_h,
  input  logic             idx_l,
  input  logic             idx_m,
  input  logic [VEC_W-1:0] vec_a,
  input  logic [VEC_W-1:0] vec_b,
  input  logic [VEC_W-1:0] vec_acc,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             sat_flag,
  output logic             bad_code
);
  localparam int N_HALF   = VEC_W / HALF_W;
  localparam int N_SINGLE = VEC_W / SINGLE_W;

  logic [HALF_W-1:0]   b_half;
  logic [SINGLE_W-1:0] b_single;
  logic [HALF_W-1:0]   r_half   [N_HALF];
  logic [SINGLE_W-1:0] r_single [N_SINGLE];
  logic [N_HALF-1:0]   s_half;
  logic [N_SINGLE-1:0] s_single;

  sqm_bsel #(.VEC_W(VEC_W), .HW(HALF_W), .SW(SINGLE_W)) u_bsel (
    .vec_b   (vec_b),
    .idx_h   (idx_h),
    .idx_l   (idx_l),
    .idx_m   (idx_m),
    .b_half  (b_half),
    .b_single(b_single)
  );

  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    sqm_lane #(.ESIZE(HALF_W)) u_lane (
      .a  (vec_a[g*HALF_W +: HALF_W]),
      .b  (b_half),
      .acc(vec_acc[g*HALF_W +: HALF_W]),
      .res(r_half[g]),
      .sat(s_half[g])
    );
  end

  for (genvar g = 0; g < N_SINGLE; g++) begin : g_single
    sqm_lane #(.ESIZE(SINGLE_W)) u_lane (
      .a  (vec_a[g*SINGLE_W +: SINGLE_W]),
      .b  (b_single),
      .acc(vec_acc[g*SINGLE_W +: SINGLE_W]),
      .res(r_single[g]),
      .sat(s_single[g])
    );
  end

  // Lane masking by vector width and scalar select
  int         act_half, act_single;
  logic [VEC_W-1:0] res_c;
  logic       sat_c, illegal_c;
  lane_code_e code;

  always_comb begin
    code       = lane_code_e'(lane_code);
    act_half   = scalar_mode ? 1 : (wide_q ? N_HALF : N_HALF/2);
    act_single = scalar_mode ? 1 : (wide_q ? N_SINGLE : N_SINGLE/2);
    res_c      = '0;
    sat_c      = 1'b0;
    illegal_c  = 1'b0;
    unique case (code)
      LC_HALF: begin
        for (int i = 0; i < N_HALF; i++) begin
          if (i < act_half) begin
            res_c[i*HALF_W +: HALF_W] = r_half[i];
            sat_c = sat_c | s_half[i];
          end
        end
      end
      LC_SINGLE: begin
        for (int i = 0; i < N_SINGLE; i++) begin
          if (i < act_single) begin
            res_c[i*SINGLE_W +: SINGLE_W] = r_single[i];
            sat_c = sat_c | s_single[i];
          end
        end
      end
      default: illegal_c = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      bad_code  <= 1'b0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= res_c;
        bad_code <= illegal_c;
      end
      sat_flag <= (sat_flag & ~sat_clr) | (in_valid & sat_c & ~illegal_c);
    end
  end
endmodule

// File: rtl/sqm_checker.sv
module sqm_checker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       lane_code,
  input logic             wide_q,
  input logic             scalar_mode,
  input logic             sat_clr,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             sat_flag,
  input logic             bad_code
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r9_result_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(bad_code));
  a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_q) |=> result[VEC_W-1:VEC_W/2] == '0);
  a_r7_scalar_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar_mode) |=> result[VEC_W-1:32] == '0);
  a_r8_bad_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && bad_code) |-> result == '0);
  a_r8_bad_flag_kept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (lane_code == 2'b00 || lane_code == 2'b11) && !sat_clr)
      |=> sat_flag == $past(sat_flag));
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !sat_clr) |=> sat_flag);
  a_r4_flag_cleared: assert property (@(posedge clk) disable iff (rst)
    (sat_clr && !in_valid) |=> !sat_flag);
  a_r4_rise_needs_input: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_flag) |-> $past(in_valid));
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (!out_valid && !sat_flag && !bad_code && result == '0));
endmodule

bind sqm_unit sqm_checker #(.VEC_W(VEC_W)) u_sqm_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .lane_code  (lane_code),
  .wide_q     (wide_q),
  .scalar_mode(scalar_mode),
  .sat_clr    (sat_clr),
  .out_valid  (out_valid),
  .result     (result),
  .sat_flag   (sat_flag),
  .bad_code   (bad_code)
);

// File: tb/tb_sqm_unit.sv
`timescale 1ns/1ps
module tb_sqm_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, wide_q, scalar_mode, idx_h, idx_l, idx_m, sat_clr;
  logic [1:0]   lane_code;
  logic [127:0] vec_a, vec_b, vec_acc;
  logic         out_valid, sat_flag, bad_code;
  logic [127:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit exp_flag = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sqm_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .lane_code(lane_code),
    .wide_q(wide_q), .scalar_mode(scalar_mode), .idx_h(idx_h), .idx_l(idx_l),
    .idx_m(idx_m), .vec_a(vec_a), .vec_b(vec_b), .vec_acc(vec_acc),
    .sat_clr(sat_clr), .out_valid(out_valid), .result(result),
    .sat_flag(sat_flag), .bad_code(bad_code)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Wide-integer model of one lane
  function automatic logic [31:0] lane_model(input int e, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] c, output bit sat);
    logic signed [95:0] av, bv, cv, t, hi, lo;
    if (e == 16) begin
      av = $signed({{80{a[15]}}, a[15:0]});
      bv = $signed({{80{b[15]}}, b[15:0]});
      cv = $signed({{80{c[15]}}, c[15:0]});
    end else begin
      av = $signed({{64{a[31]}}, a});
      bv = $signed({{64{b[31]}}, b});
      cv = $signed({{64{c[31]}}, c});
    end
    t  = (cv <<< e) - (av * bv) - (av * bv);
    t  = t + (96'sd1 <<< (e - 1));
    t  = t >>> e;
    hi = (96'sd1 <<< (e - 1)) - 96'sd1;
    lo = -(96'sd1 <<< (e - 1));
    sat = 1'b0;
    if (t > hi) begin t = hi; sat = 1'b1; end
    if (t < lo) begin t = lo; sat = 1'b1; end
    return t[31:0];
  endfunction

  function automatic logic [127:0] vec_model(input logic [1:0] code, input bit q,
      input bit sc, input bit h, input bit l, input bit m, input logic [127:0] a,
      input logic [127:0] b, input logic [127:0] c, output bit sat, output bit bad);
    logic [127:0] r = '0;
    int e, n, k;
    logic [31:0] bsel, lr;
    bit ls;
    sat = 1'b0;
    bad = !(code == 2'b01 || code == 2'b10);
    if (bad) return r;
    e = (code == 2'b01) ? 16 : 32;
    n = sc ? 1 : ((q ? 128 : 64) / e);
    k = (e == 16) ? {29'd0, h, l, m} : {30'd0, h, l};
    bsel = (e == 16) ? {16'd0, b[k*16 +: 16]} : b[k*32 +: 32];
    for (int i = 0; i < n; i++) begin
      if (e == 16) begin
        lr = lane_model(16, {16'd0, a[i*16 +: 16]}, bsel, {16'd0, c[i*16 +: 16]}, ls);
        r[i*16 +: 16] = lr[15:0];
      end else begin
        lr = lane_model(32, a[i*32 +: 32], bsel, c[i*32 +: 32], ls);
        r[i*32 +: 32] = lr;
      end
      sat = sat | ls;
    end
    return r;
  endfunction

  task automatic run_op(input logic [1:0] code, input bit q, input bit sc,
      input bit h, input bit l, input bit m, input logic [127:0] a,
      input logic [127:0] b, input logic [127:0] c, input bit clr, input string req);
    logic [127:0] exp_r;
    bit s, bad;
    exp_r = vec_model(code, q, sc, h, l, m, a, b, c, s, bad);
    @(negedge clk);
    in_valid = 1'b1; lane_code = code; wide_q = q; scalar_mode = sc;
    idx_h = h; idx_l = l; idx_m = m; vec_a = a; vec_b = b; vec_acc = c;
    sat_clr = clr;
    exp_flag = (exp_flag & ~clr) | (s & ~bad);
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
    check(out_valid == 1'b1, {req, " R9 valid"}, 128'(out_valid), 128'd1);
    check(result == exp_r, {req, " result"}, result, exp_r);
    check(bad_code == bad, {req, " R8 bad_code"}, 128'(bad_code), 128'(bad));
    check(sat_flag == exp_flag, {req, " R4 flag"}, 128'(sat_flag), 128'(exp_flag));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [127:0] edge128(input int e);
    logic [127:0] v = '0;
    for (int i = 0; i < 128 / e; i++) begin
      int p = $urandom_range(3);
      logic [31:0] x;
      x = (p == 0) ? 32'h8000_0000 : (p == 1) ? 32'h7fff_ffff :
          (p == 2) ? 32'hffff_ffff : $urandom();
      if (e == 16) v[i*16 +: 16] = x[31:16];
      else         v[i*32 +: 32] = x;
    end
    return v;
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; lane_code = 2'b01; wide_q = 1'b0;
    scalar_mode = 1'b0; idx_h = 0; idx_l = 0; idx_m = 0; vec_a = '0;
    vec_b = '0; vec_acc = '0; sat_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check(!out_valid && !sat_flag && !bad_code && result == '0, "R10 reset",
          {out_valid, sat_flag, bad_code, result[124:0]}, '0);

    // R2 simple value: acc=1, a=b=0 -> (1<<16 + 2^15)>>16 = 1 per lane
    run_op(2'b01, 1, 0, 0, 0, 0, '0, '0, {8{16'h0001}}, 0, "R1 R2 simple");
    // R3 R2 most-negative corner, 16-bit, saturates to 8000
    run_op(2'b01, 1, 0, 1, 1, 1, {8{16'h8000}}, {8{16'h8000}}, {8{16'h8000}}, 0,
           "R3 corner16");
    check(result == {8{16'h8000}}, "R3 corner16 bound", result, {8{16'h8000}});
    // R4 clear and set same cycle: set wins
    run_op(2'b10, 1, 0, 0, 1, 0, {4{32'h8000_0000}}, {4{32'h8000_0000}},
           {4{32'h8000_0000}}, 1, "R4 clear+set corner32");
    // R4 clear with no clamp
    run_op(2'b10, 0, 0, 0, 0, 0, '0, '0, '0, 1, "R4 clear");
    check(sat_flag == 1'b0, "R4 cleared", 128'(sat_flag), '0);
    // R5 index selection: distinct b lanes
    for (int k = 0; k < 8; k++)
      run_op(2'b01, 1, 0, k[2], k[1], k[0], rnd128(),
             {16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1, 16'd0} * 128'd1000,
             rnd128(), 0, "R5 index16");
    for (int k = 0; k < 4; k++)
      run_op(2'b10, 1, 0, k[1], k[0], 1, rnd128(), rnd128(), rnd128(), 0,
             "R5 index32");
    // R6 narrow vector, R7 scalar
    run_op(2'b01, 0, 0, 0, 1, 1, rnd128(), rnd128(), rnd128(), 0, "R6 narrow16");
    run_op(2'b10, 0, 0, 0, 1, 0, rnd128(), rnd128(), rnd128(), 0, "R6 narrow32");
    run_op(2'b01, 1, 1, 1, 0, 1, rnd128(), rnd128(), rnd128(), 0, "R7 scalar16");
    run_op(2'b10, 1, 1, 1, 1, 0, rnd128(), rnd128(), rnd128(), 0, "R7 scalar32");
    // R8 illegal codes with clamping operands: flag unchanged
    run_op(2'b00, 1, 0, 0, 0, 0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h8000}}, 0,
           "R8 code00");
    run_op(2'b11, 1, 0, 0, 0, 0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h8000}}, 0,
           "R8 code11");
    // R9 hold while idle
    held = result;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 idle valid", 128'(out_valid), '0);
    check(result == held, "R9 idle hold", result, held);
    // Random mix
    for (int t = 0; t < 400; t++) begin
      logic [1:0] code;
      int e;
      logic [127:0] a, b, c;
      code = ($urandom_range(15) == 0) ? 2'($urandom_range(1) * 3)
                                       : 2'($urandom_range(1) + 1);
      e = (code == 2'b10) ? 32 : 16;
      a = ($urandom_range(2) == 0) ? edge128(e) : rnd128();
      b = ($urandom_range(2) == 0) ? edge128(e) : rnd128();
      c = ($urandom_range(2) == 0) ? edge128(e) : rnd128();
      run_op(code, 1'($urandom_range(1)), ($urandom_range(7) == 0),
             1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
             a, b, c, ($urandom_range(9) == 0), "R2 R3 R6 random");
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule